// File: doc/BRIEF.md
# Flash Controller Protected Configuration and Interrupt Registers

This unit is the register front end of a flash memory controller. A CPU reaches it over a simple 32-bit register bus. The bus carries a word address, a write strobe, a read strobe, four byte-lane enables, write data and combinational read data. The unit holds the two settings that the flash datapath must not lose by accident: the interface configuration and the bus timing word. Both are guarded by a key register. Writing the key opens them for exactly one write. After that write they close again.

The unit also collects six event pulses from the flash datapath and the ECC engine. Each pulse sets a sticky flag in an interrupt status register, and reading that register clears the flags. A mask register selects which flags drive the level interrupt line. A raw status register keeps a view of the most recent operation: which ready events have occurred, whether the decoder found errors and how many symbols it corrected, and whether decoding failed. Command writes clear this view. The reset command (0xFF) also clears the interrupt flags and closes the key.

Top module: `flash_cfg_irq_regs`

## Requirements
- R1: After reset the configuration register reads 0, the timing register reads all ones (0x3FFFFFF), the mask, the interrupt status and the raw status read 0, the key register reads 0 (closed), and the interrupt output is low.
- R2: The registers sit at these word addresses: 0 command, 1 configuration, 2 timing, 3 key, 4 interrupt mask, 5 interrupt status, 6 raw status. Every other address reads as 0.
- R3: A write to address 3 opens the protected registers only when byte lanes 0 and 1 are both enabled, bits [15:0] equal 0xA25E, and every enabled upper byte lane carries zero. Reading address 3 returns 1 in bit 0 while the registers are open. Any other value written to address 3 closes them. A write to any other address never opens them.
- R4: While the protected registers are closed, a write to the configuration or timing register is ignored and the old value is kept.
- R5: The first write to the configuration or timing register after an opening is accepted, and it closes the registers again. A second protected write needs a new key write. Writes to unprotected registers in between do not use up the opening.
- R6: The configuration register has four bits, taken from byte lane 0: bit 3 write protect, bit 2 large-block page, bit 1 five-byte address, bit 0 16-bit bus. It drives `cfg_o`.
- R7: The timing register is 26 bits wide. From the LSB up it holds write-low [3:0], write-high [7:4], read-low [11:8], read-high [15:12], turnaround [18:16], busy delay [23:19] and chip-enable-to-access delay [25:24]. An accepted write updates only the bytes whose lane enable is set. The register drives `timing_o`.
- R8: Each event pulse sets a sticky flag in the interrupt status register: bit 0 write-protect fault, bit 1 ECC ready, bit 2 decode error, bit 3 decode failure, bit 4 controller ready, bit 5 flash ready. A read returns the flags and clears them. An event that arrives in the same cycle as the read is not lost: its flag remains set after the read.
- R9: `irq_o` is high exactly while some status flag is set whose bit in the mask register (address 4, same bit order) is 1.
- R10: The raw status register holds these bits: bit 0 flash ready seen, bit 1 controller ready seen, bit 2 ECC ready seen, bit 3 errors detected, bits [5:4] the corrected-symbol count minus one (captured from `dec_corr_cnt` on a decode-error pulse), bit 6 decoder failure. Each bit is set by its event.
- R11: A command write (address 3 is not involved; address 0 with byte lane 0 enabled) clears the raw status. The value 0xFF also clears the interrupt flags and closes the protected registers. The mask, configuration and timing registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a status read clears on the clock edge |
| bus_be | input | 4 | Byte-lane enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| ev_flash_rdy | input | 1 | Flash ready pulse |
| ev_ctrl_rdy | input | 1 | Controller ready pulse |
| ev_ecc_rdy | input | 1 | ECC ready pulse |
| ev_dec_err | input | 1 | Decoder found correctable errors |
| ev_dec_fail | input | 1 | Decoder failure pulse |
| ev_wp_fault | input | 1 | Write-protect fault pulse |
| dec_corr_cnt | input | 2 | Corrected symbols minus one, valid with ev_dec_err |
| cfg_o | output | 4 | Interface configuration |
| timing_o | output | 26 | Bus timing word |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench probes the key with near-miss writes: a wrong value, a full-word write with a nonzero upper half, and a write to another register. A design that accepted any of these would show a changed configuration. After each accepted protected write it tries a second one. A design that relocked late, or relocked on unrelated writes, would accept the second write or reject the first. The bench reads the status register in the same cycle that a decode-failure pulse arrives. A design whose clear beats the set would return zero on the following read. Partial-lane timing writes, masked versus unmasked flags, and the reset command also appear. A wrong reset command would leave the flags, the raw view or the opening alive, or would wipe the mask.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  localparam int CFG_W = 4;
  localparam int TIM_W = 26;
  localparam int EV_W  = 6;
  localparam int RAW_W = 7;

  localparam logic [15:0] UNLOCK_KEY = 16'hA25E;
  localparam logic [7:0]  CMD_RESET  = 8'hFF;

  localparam int A_CMD  = 0;
  localparam int A_CFG  = 1;
  localparam int A_TIM  = 2;
  localparam int A_KEY  = 3;
  localparam int A_MASK = 4;
  localparam int A_STAT = 5;
  localparam int A_RAW  = 6;

  localparam int EV_WP    = 0;
  localparam int EV_ECC   = 1;
  localparam int EV_DERR  = 2;
  localparam int EV_DFAIL = 3;
  localparam int EV_CRDY  = 4;
  localparam int EV_FRDY  = 5;

  localparam int RW_FRDY = 0;
  localparam int RW_CRDY = 1;
  localparam int RW_ECC  = 2;
  localparam int RW_ERR  = 3;
  localparam int RW_CNT  = 4;
  localparam int RW_FAIL = 6;
endpackage

// File: rtl/fcr_lock_bank.sv
module fcr_lock_bank #(
  parameter int CFG_W = 4,
  parameter int TIM_W = 26,
  parameter logic [TIM_W-1:0] TIM_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_ok,
  input  logic             key_bad,
  input  logic             relock,
  input  logic             cfg_sel,
  input  logic             tim_sel,
  input  logic [3:0]       be,
  input  logic [TIM_W-1:0] wdata,
  output logic [CFG_W-1:0] cfg_q,
  output logic [TIM_W-1:0] tim_q,
  output logic             open_q
);
  logic             open_n;
  logic [CFG_W-1:0] cfg_n;
  logic [TIM_W-1:0] tim_n;
  logic             cfg_en;
  logic             tim_en;

  assign cfg_en = cfg_sel && open_q && be[0];
  assign tim_en = tim_sel && open_q;

  always_comb begin
    open_n = open_q;
    if (key_ok)
      open_n = 1'b1;
    else if (key_bad || relock || cfg_sel || tim_sel)
      open_n = 1'b0;
  end

  always_comb begin
    cfg_n = cfg_q;
    if (cfg_en)
      cfg_n = wdata[CFG_W-1:0];
  end

  for (genvar i = 0; i < TIM_W; i++) begin : g_tim_bit
    assign tim_n[i] = (tim_en && be[i/8]) ? wdata[i] : tim_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cfg_q  <= '0;
      tim_q  <= TIM_RST;
    end else begin
      open_q <= open_n;
      cfg_q  <= cfg_n;
      tim_q  <= tim_n;
    end
  end

  // R3
  open_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_q) |-> $past(key_ok));

  // R4
  cfg_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> $past(open_q && cfg_sel));

  // R4
  tim_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tim_q) |-> $past(open_q && tim_sel));

  // R5
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel || tim_sel) |=> !open_q);
endmodule

// File: rtl/fcr_irq_unit.sv
module fcr_irq_unit
  import fcr_pkg::*;
#(
  parameter int N_EV = EV_W,
  parameter int N_RAW = RAW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EV-1:0]  ev,
  input  logic [1:0]       corr_cnt,
  input  logic             mask_wr,
  input  logic [N_EV-1:0]  mask_wdata,
  input  logic             stat_rd,
  input  logic             cmd_wr,
  input  logic             soft_clr,
  output logic [N_EV-1:0]  mask_q,
  output logic [N_EV-1:0]  flag_q,
  output logic [N_RAW-1:0] raw_q,
  output logic             irq_o
);
  logic [N_EV-1:0]  mask_n;
  logic [N_EV-1:0]  flag_n;
  logic [N_RAW-1:0] raw_n;
  logic             flag_wipe;

  assign flag_wipe = stat_rd || soft_clr;

  always_comb begin
    mask_n = mask_q;
    if (mask_wr)
      mask_n = mask_wdata;
  end

  always_comb begin
    flag_n = flag_q;
    if (flag_wipe)
      flag_n = '0;
    flag_n = flag_n | ev;
  end

  always_comb begin
    raw_n = raw_q;
    if (cmd_wr)
      raw_n = '0;
    if (ev[EV_FRDY])
      raw_n[RW_FRDY] = 1'b1;
    if (ev[EV_CRDY])
      raw_n[RW_CRDY] = 1'b1;
    if (ev[EV_ECC])
      raw_n[RW_ECC] = 1'b1;
    if (ev[EV_DERR]) begin
      raw_n[RW_ERR] = 1'b1;
      raw_n[RW_CNT +: 2] = corr_cnt;
    end
    if (ev[EV_DFAIL])
      raw_n[RW_FAIL] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      flag_q <= '0;
      raw_q  <= '0;
    end else begin
      mask_q <= mask_n;
      flag_q <= flag_n;
      raw_q  <= raw_n;
    end
  end

  assign irq_o = |(flag_q & mask_q);

  // R8
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |=> ((flag_q & $past(ev)) == $past(ev)));

  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(|ev) || $past(mask_wr)));

  // R10
  raw_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev[EV_DFAIL] |=> raw_q[RW_FAIL]);

  // R11
  raw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !(|ev)) |=> (raw_q == '0));
endmodule

// File: rtl/flash_cfg_irq_regs.sv
module flash_cfg_irq_regs
  import fcr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [TIM_W-1:0] TIM_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ev_flash_rdy,
  input  logic              ev_ctrl_rdy,
  input  logic              ev_ecc_rdy,
  input  logic              ev_dec_err,
  input  logic              ev_dec_fail,
  input  logic              ev_wp_fault,
  input  logic [1:0]        dec_corr_cnt,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [TIM_W-1:0]  timing_o,
  output logic              irq_o
);
  logic wr_cmd, wr_cfg, wr_tim, wr_key, wr_mask, rd_stat;
  logic key_ok, key_bad, cmd_wr, soft_rst;
  logic upper_clean;
  logic open_q;
  logic [EV_W-1:0]  ev_vec;
  logic [EV_W-1:0]  mask_q, flag_q;
  logic [RAW_W-1:0] raw_q;

  assign wr_cmd  = bus_wr && (bus_addr == ADDR_W'(A_CMD));
  assign wr_cfg  = bus_wr && (bus_addr == ADDR_W'(A_CFG));
  assign wr_tim  = bus_wr && (bus_addr == ADDR_W'(A_TIM));
  assign wr_key  = bus_wr && (bus_addr == ADDR_W'(A_KEY));
  assign wr_mask = bus_wr && (bus_addr == ADDR_W'(A_MASK)) && bus_be[0];
  assign rd_stat = bus_rd && (bus_addr == ADDR_W'(A_STAT));

  assign upper_clean = (!bus_be[2] || (bus_wdata[23:16] == 8'h00)) &&
                       (!bus_be[3] || (bus_wdata[31:24] == 8'h00));
  assign key_ok   = wr_key && (bus_be[1:0] == 2'b11) &&
                    (bus_wdata[15:0] == UNLOCK_KEY) && upper_clean;
  assign key_bad  = wr_key && !key_ok;
  assign cmd_wr   = wr_cmd && bus_be[0];
  assign soft_rst = cmd_wr && (bus_wdata[7:0] == CMD_RESET);

  always_comb begin
    ev_vec           = '0;
    ev_vec[EV_WP]    = ev_wp_fault;
    ev_vec[EV_ECC]   = ev_ecc_rdy;
    ev_vec[EV_DERR]  = ev_dec_err;
    ev_vec[EV_DFAIL] = ev_dec_fail;
    ev_vec[EV_CRDY]  = ev_ctrl_rdy;
    ev_vec[EV_FRDY]  = ev_flash_rdy;
  end

  fcr_lock_bank #(
    .CFG_W   (CFG_W),
    .TIM_W   (TIM_W),
    .TIM_RST (TIM_RST)
  ) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .key_ok  (key_ok),
    .key_bad (key_bad),
    .relock  (soft_rst),
    .cfg_sel (wr_cfg),
    .tim_sel (wr_tim),
    .be      (bus_be),
    .wdata   (bus_wdata[TIM_W-1:0]),
    .cfg_q   (cfg_o),
    .tim_q   (timing_o),
    .open_q  (open_q)
  );

  fcr_irq_unit #(
    .N_EV  (EV_W),
    .N_RAW (RAW_W)
  ) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev         (ev_vec),
    .corr_cnt   (dec_corr_cnt),
    .mask_wr    (wr_mask),
    .mask_wdata (bus_wdata[EV_W-1:0]),
    .stat_rd    (rd_stat),
    .cmd_wr     (cmd_wr),
    .soft_clr   (soft_rst),
    .mask_q     (mask_q),
    .flag_q     (flag_q),
    .raw_q      (raw_q),
    .irq_o      (irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == ADDR_W'(A_CFG))
        bus_rdata[CFG_W-1:0] = cfg_o;
      else if (bus_addr == ADDR_W'(A_TIM))
        bus_rdata[TIM_W-1:0] = timing_o;
      else if (bus_addr == ADDR_W'(A_KEY))
        bus_rdata[0] = open_q;
      else if (bus_addr == ADDR_W'(A_MASK))
        bus_rdata[EV_W-1:0] = mask_q;
      else if (bus_addr == ADDR_W'(A_STAT))
        bus_rdata[EV_W-1:0] = flag_q;
      else if (bus_addr == ADDR_W'(A_RAW))
        bus_rdata[RAW_W-1:0] = raw_q;
    end
  end

  // R11
  soft_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !open_q);
endmodule

// File: tb/flash_cfg_irq_regs_bench.sv
module flash_cfg_irq_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } rd_item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [3:0]    bus_be = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          ev_flash_rdy = 1'b0, ev_ctrl_rdy = 1'b0, ev_ecc_rdy = 1'b0;
  logic          ev_dec_err = 1'b0, ev_dec_fail = 1'b0, ev_wp_fault = 1'b0;
  logic [1:0]    dec_corr_cnt = '0;
  logic [3:0]    cfg_o;
  logic [25:0]   timing_o;
  logic          irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  rd_item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cfg_irq_regs u_flash_cfg_irq_regs (
    .clk, .rst_n, .bus_addr, .bus_wr, .bus_rd, .bus_be, .bus_wdata, .bus_rdata,
    .ev_flash_rdy, .ev_ctrl_rdy, .ev_ecc_rdy, .ev_dec_err, .ev_dec_fail,
    .ev_wp_fault, .dec_corr_cnt, .cfg_o, .timing_o, .irq_o
  );

  // monitor: pops one expected item per read cycle
  always @(negedge clk) begin
    if (bus_rd) begin
      rd_item_t it;
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL scoreboard: read with no expected item, actual %h", bus_rdata);
      end else begin
        it = sb.pop_front();
        if (bus_rdata !== it.exp) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d, input logic [3:0] be);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d; bus_be = be;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    sb.push_back('{exp: e, tag: tag});
    bus_rd = 1'b1; bus_addr = AW'(a);
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic drive_ev(input logic [5:0] v, input logic [1:0] cnt);
    ev_wp_fault = v[0]; ev_ecc_rdy = v[1]; ev_dec_err = v[2];
    ev_dec_fail = v[3]; ev_ctrl_rdy = v[4]; ev_flash_rdy = v[5];
    dec_corr_cnt = cnt;
  endtask

  task automatic pulse(input logic [5:0] v, input logic [1:0] cnt);
    @(posedge clk); #1;
    drive_ev(v, cnt);
    @(posedge clk); #1;
    drive_ev(6'h00, 2'b00);
  endtask

  task automatic rd_with_ev(input logic [5:0] v, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    sb.push_back('{exp: e, tag: tag});
    bus_rd = 1'b1; bus_addr = AW'(5);
    drive_ev(v, 2'b00);
    @(posedge clk); #1;
    bus_rd = 1'b0;
    drive_ev(6'h00, 2'b00);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string tag);
    @(negedge clk);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, e);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 / R2: reset values and map
    chk(32'(irq_o), 0, "R1 irq after reset");
    rd(1, 32'h0, "R1 cfg reset");
    rd(2, 32'h03FF_FFFF, "R1 timing reset");
    rd(4, 32'h0, "R1 mask reset");
    rd(5, 32'h0, "R1 status reset");
    rd(6, 32'h0, "R1 raw reset");
    rd(3, 32'h0, "R1 key closed at reset");
    rd(7, 32'h0, "R2 unmapped address");

    // R4: locked write ignored
    wr(1, 32'h6, 4'hF);
    rd(1, 32'h0, "R4 locked cfg write ignored");

    // R3: wrong key, and other register, do not open
    wr(3, 32'h1234, 4'h3);
    wr(1, 32'h6, 4'hF);
    rd(1, 32'h0, "R3 wrong key");
    wr(4, 32'h0, 4'hF);
    wr(1, 32'h6, 4'hF);
    rd(1, 32'h0, "R3 other register write");

    // R3 / R5 / R6: accepted once
    wr(3, 32'hA25E, 4'h3);
    rd(3, 32'h1, "R3 key opens");
    wr(1, 32'h6, 4'hF);
    rd(1, 32'h6, "R5 first protected write");
    chk(32'(cfg_o), 32'h6, "R6 cfg_o drive");
    wr(1, 32'hF, 4'hF);
    rd(1, 32'h6, "R5 second write refused");

    // R5: unprotected writes do not consume opening
    wr(3, 32'hA25E, 4'h3);
    wr(4, 32'h0, 4'h1);
    wr(1, 32'h9, 4'h1);
    rd(1, 32'h9, "R5 opening survives mask write");

    // R3: word write with nonzero upper half
    wr(3, 32'h0001_A25E, 4'hF);
    wr(1, 32'h3, 4'hF);
    rd(1, 32'h9, "R3 dirty upper half");

    // R7: timing full and partial
    wr(3, 32'h0000_A25E, 4'hF);
    wr(2, 32'h0123456, 4'hF);
    rd(2, 32'h0123456, "R7 timing full write");
    chk(32'(timing_o), 32'h0123456, "R7 timing_o drive");
    wr(2, 32'h0, 4'hF);
    rd(2, 32'h0123456, "R5 timing second write refused");
    wr(3, 32'hA25E, 4'h3);
    wr(2, 32'hFFFF_FFAB, 4'h1);
    rd(2, 32'h01234AB, "R7 lane 0 only");

    // R8 / R9: masked flag
    pulse(6'h10, 2'b00);
    chk(32'(irq_o), 0, "R9 masked flag no irq");
    rd(5, 32'h10, "R8 status read");
    rd(5, 32'h0, "R8 cleared by read");

    // R9: unmasked flag
    wr(4, 32'h20, 4'h1);
    pulse(6'h20, 2'b00);
    chk(32'(irq_o), 1, "R9 unmasked flag irq");
    rd(5, 32'h20, "R8 flash ready flag");
    chk(32'(irq_o), 0, "R9 irq drops after read");

    // R8: collision
    pulse(6'h01, 2'b00);
    chk(32'(irq_o), 0, "R9 wp fault masked");
    rd_with_ev(6'h08, 32'h01, "R8 read during event");
    rd(5, 32'h08, "R8 event kept");

    // R10 / R11: raw status
    wr(0, 32'h01, 4'h1);
    rd(6, 32'h0, "R11 command clears raw");
    pulse(6'h32, 2'b00);
    rd(6, 32'h07, "R10 ready bits");
    pulse(6'h04, 2'b10);
    rd(6, 32'h2F, "R10 error and count");
    pulse(6'h08, 2'b00);
    rd(6, 32'h6F, "R10 decoder failure");
    wr(0, 32'h00, 4'h1);
    rd(6, 32'h0, "R11 new command clears raw");
    chk(32'(irq_o), 1, "R11 ordinary command keeps flags");

    // R11: reset command
    wr(3, 32'hA25E, 4'h3);
    wr(0, 32'hFF, 4'h1);
    chk(32'(irq_o), 0, "R11 reset command clears flags");
    rd(3, 32'h0, "R11 reset command closes key");
    wr(1, 32'h5, 4'hF);
    rd(1, 32'h9, "R11 cfg kept and locked");
    rd(5, 32'h0, "R11 status cleared");
    rd(4, 32'h20, "R11 mask kept");
    rd(2, 32'h01234AB, "R11 timing kept");

    @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: actual %0d left expected 0", sb.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule